// File: doc/BRIEF.md
# Two-Output PWM Edge and Trigger Generator

This block is the timing core of one channel of a digital power controller. A free-running period counter advances on the fast PWM clock. It places the rising and falling edges of two gate-drive outputs, A and B, by comparing the counter against programmed edge positions. A single trim offset is added to the two falling-edge positions, so a control loop can stretch or shrink both pulses together without rewriting each edge.

The three late edges (A fall, B rise, B fall) are written as a coarse count in the upper bits plus a 4-bit fine fraction in the lowest bits. The counter compares only the coarse part. The fine code of each edge is driven out for a sub-cycle delay stage outside this block.

The block also emits three kinds of pulse and window:
- a one-cycle phase pulse at a programmed count, which keeps a second channel aligned for interleaving;
- one or more one-cycle sample pulses that start the front-end converter. The sample position is written in units of four fast cycles, and the pulses can repeat evenly across the period;
- blanking windows after every edge of A and B, used to mask fault comparators.

All programmed values are copied into the active set only when the counter wraps.

Top module: `dpwm_edge_gen`

## Requirements
- R1: `cnt_o` counts 0, 1, ..., P and then returns to 0, where P is the active `period_i`. A period therefore lasts P+1 fast clock cycles.
- R2: In the cycle after the counter equals `rise_a_i`, `pwm_a_o` goes high.
- R3: `pwm_a_o` goes low in the cycle after the counter equals bits [CW+FW:FW] of (`fall_a_i` + `trim_i`). If the rise and fall compares match on the same count, the fall wins. If the fall count exceeds P, A never falls.
- R4: `pwm_b_o` goes high in the cycle after the counter equals bits [CW+FW-1:FW] of `rise_b_i`. It goes low in the cycle after the counter equals the coarse part of (`fall_b_i` + `trim_i`). The fall wins on a tie.
- R5: The trim is added only to the two falling edges. `fine_af_o` and `fine_bf_o` are bits [FW-1:0] of the two trimmed sums, so a carry out of the fine field moves the coarse count. `fine_br_o` is bits [FW-1:0] of `rise_b_i`.
- R6: `phase_trig_o` is high for exactly the one cycle after the counter equals `phase_i`.
- R7: Sample pulses fall at fast-clock counts 4*S + k*((P+1) >> O), where S is `sample_i` and O is `ovs_i`. The index k runs from 0 to 2^O - 1, so O = 0, 1, 2 and 3 give 1, 2, 4 and 8 pulses. Only counts no greater than P fire. Each pulse appears in the cycle after the counter reaches its count.
- R8: Every input except reset is a shadow value. It is copied into the active set on the clock edge where the counter wraps from P to 0, so a change in mid-period has no effect until the next period.
- R9: `blank_a_o` (`blank_b_o`) is high for `blank_len_i` cycles starting with the cycle in which A (B) changes level. A new edge restarts the window. A length of 0 gives no blanking.
- R10: During reset, every output is 0. On the first clock after reset, the inputs are loaded and the counter starts at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast PWM clock |
| rst_n | input | 1 | Active-low synchronous reset |
| period_i | input | CW | Last count of the period (P) |
| rise_a_i | input | CW | Coarse count of A rise |
| fall_a_i | input | CW+FW | A fall, coarse and fine |
| rise_b_i | input | CW+FW | B rise, coarse and fine |
| fall_b_i | input | CW+FW | B fall, coarse and fine |
| trim_i | input | CW+FW | Offset added to both falling edges |
| phase_i | input | CW | Count of the phase pulse |
| sample_i | input | CW-2 | Sample position in units of four cycles |
| ovs_i | input | 2 | Oversampling code, 2^code pulses |
| blank_len_i | input | BW | Blanking window length in cycles |
| cnt_o | output | CW | Period counter |
| pwm_a_o | output | 1 | Output A |
| pwm_b_o | output | 1 | Output B |
| fine_af_o | output | FW | Fine code of trimmed A fall |
| fine_br_o | output | FW | Fine code of B rise |
| fine_bf_o | output | FW | Fine code of trimmed B fall |
| phase_trig_o | output | 1 | Phase sync pulse |
| sample_trig_o | output | 1 | Converter start pulse |
| blank_a_o | output | 1 | Blanking window after A edges |
| blank_b_o | output | 1 | Blanking window after B edges |

## Verification
The bench sweeps every count of full periods over several configurations and targets a specific set of corner cases:

- A trim whose fine part carries into the coarse count. A design that ignored the carry would fall one cycle early and report the wrong fine code.
- A fall placed exactly at P. A fall placed beyond P, which must hold A high.
- Equal rise and fall counts, which must hold B low.
- Oversampling where the last spaced pulses pass P and must be dropped. Period 7 at eight pulses, which must fire on every count including the one that wraps.
- A configuration change in the middle of a period, checked over the rest of that period. A design with no shadowing would move edges early.
- Windows that touch, where a missed restart shows as a truncated blank.

// File: rtl/dpwm_edge_gen.sv
module dpwm_edge_gen #(
  parameter int CW = 14,
  parameter int FW = 4,
  parameter int BW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CW-1:0]     period_i,
  input  logic [CW-1:0]     rise_a_i,
  input  logic [CW+FW-1:0]  fall_a_i,
  input  logic [CW+FW-1:0]  rise_b_i,
  input  logic [CW+FW-1:0]  fall_b_i,
  input  logic [CW+FW-1:0]  trim_i,
  input  logic [CW-1:0]     phase_i,
  input  logic [CW-3:0]     sample_i,
  input  logic [1:0]        ovs_i,
  input  logic [BW-1:0]     blank_len_i,
  output logic [CW-1:0]     cnt_o,
  output logic              pwm_a_o,
  output logic              pwm_b_o,
  output logic [FW-1:0]     fine_af_o,
  output logic [FW-1:0]     fine_br_o,
  output logic [FW-1:0]     fine_bf_o,
  output logic              phase_trig_o,
  output logic              sample_trig_o,
  output logic              blank_a_o,
  output logic              blank_b_o
);
  localparam int EW = CW + FW;

  logic [CW-1:0] cnt, per_q, ra_q, ph_q;
  logic [EW-1:0] fa_q, rb_q, fb_q, trim_q;
  logic [CW-3:0] sm_q;
  logic [1:0]    ovs_q;
  logic [BW-1:0] bl_q, bcnt_a, bcnt_b;
  logic [CW:0]   nxt_pos;
  logic [3:0]    k_smp;

  wire [EW:0] a_fall = {1'b0, fa_q} + {1'b0, trim_q};
  wire [EW:0] b_fall = {1'b0, fb_q} + {1'b0, trim_q};

  wire wrap  = (cnt == per_q);
  wire a_set = (cnt == ra_q);
  wire a_clr = ({1'b0, cnt} == a_fall[EW:FW]);
  wire b_set = (cnt == rb_q[EW-1:FW]);
  wire b_clr = ({1'b0, cnt} == b_fall[EW:FW]);

  wire a_nxt = a_clr ? 1'b0 : (a_set ? 1'b1 : pwm_a_o);
  wire b_nxt = b_clr ? 1'b0 : (b_set ? 1'b1 : pwm_b_o);

  wire [3:0]  n_smp    = 4'd1 << ovs_q;
  wire [CW:0] smp_gap  = ({1'b0, per_q} + 1'b1) >> ovs_q;
  wire        samp_hit = ({1'b0, cnt} == nxt_pos) && (k_smp < n_smp);

  assign cnt_o     = cnt;
  assign fine_af_o = a_fall[FW-1:0];
  assign fine_br_o = rb_q[FW-1:0];
  assign fine_bf_o = b_fall[FW-1:0];
  assign blank_a_o = (bcnt_a != '0);
  assign blank_b_o = (bcnt_b != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      per_q  <= '0;
      ra_q   <= '0;
      ph_q   <= '0;
      fa_q   <= '0;
      rb_q   <= '0;
      fb_q   <= '0;
      trim_q <= '0;
      sm_q   <= '0;
      ovs_q  <= '0;
      bl_q   <= '0;
    end else if (wrap) begin
      cnt    <= '0;
      per_q  <= period_i;
      ra_q   <= rise_a_i;
      ph_q   <= phase_i;
      fa_q   <= fall_a_i;
      rb_q   <= rise_b_i;
      fb_q   <= fall_b_i;
      trim_q <= trim_i;
      sm_q   <= sample_i;
      ovs_q  <= ovs_i;
      bl_q   <= blank_len_i;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pwm_a_o      <= 1'b0;
      pwm_b_o      <= 1'b0;
      phase_trig_o <= 1'b0;
      bcnt_a       <= '0;
      bcnt_b       <= '0;
    end else begin
      pwm_a_o      <= a_nxt;
      pwm_b_o      <= b_nxt;
      phase_trig_o <= (cnt == ph_q);
      if (a_nxt != pwm_a_o)    bcnt_a <= bl_q;
      else if (bcnt_a != '0)   bcnt_a <= bcnt_a - 1'b1;
      if (b_nxt != pwm_b_o)    bcnt_b <= bl_q;
      else if (bcnt_b != '0)   bcnt_b <= bcnt_b - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nxt_pos       <= '0;
      k_smp         <= '0;
      sample_trig_o <= 1'b0;
    end else begin
      sample_trig_o <= samp_hit;
      if (wrap) begin
        nxt_pos <= {1'b0, sample_i, 2'b00};
        k_smp   <= '0;
      end else if (samp_hit) begin
        nxt_pos <= nxt_pos + smp_gap;
        k_smp   <= k_smp + 1'b1;
      end
    end
  end

  assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= per_q);
  assert_cnt_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |-> (cnt == $past(cnt) + 1'b1));
  assert_fall_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(a_set) && $past(a_clr)) |-> !pwm_a_o);
  assert_shadow_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |-> ($stable(per_q) && $stable(fa_q) && $stable(trim_q) && $stable(sm_q)));
  assert_samp_budget_R7: assert property (@(posedge clk) disable iff (!rst_n)
    k_smp <= n_smp);
  assert_blank_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((pwm_a_o != $past(pwm_a_o)) && ($past(bl_q) != '0)) |-> blank_a_o);
endmodule

// File: tb/dpwm_edge_gen_bench.sv
`timescale 1ns/1ps
module dpwm_edge_gen_bench;
  typedef struct packed {
    int p; int e1; int e2; int e3; int e4; int adj; int ph; int sm; int ovs; int l;
  } cfg_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [13:0] period_i = '0, rise_a_i = '0, phase_i = '0;
  logic [17:0] fall_a_i = '0, rise_b_i = '0, fall_b_i = '0, trim_i = '0;
  logic [11:0] sample_i = '0;
  logic [1:0]  ovs_i = '0;
  logic [5:0]  blank_len_i = '0;
  logic [13:0] cnt_o;
  logic pwm_a_o, pwm_b_o, phase_trig_o, sample_trig_o, blank_a_o, blank_b_o;
  logic [3:0] fine_af_o, fine_br_o, fine_bf_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dpwm_edge_gen u_dpwm_edge_gen (
    .clk(clk), .rst_n(rst_n), .period_i(period_i), .rise_a_i(rise_a_i),
    .fall_a_i(fall_a_i), .rise_b_i(rise_b_i), .fall_b_i(fall_b_i),
    .trim_i(trim_i), .phase_i(phase_i), .sample_i(sample_i), .ovs_i(ovs_i),
    .blank_len_i(blank_len_i), .cnt_o(cnt_o), .pwm_a_o(pwm_a_o),
    .pwm_b_o(pwm_b_o), .fine_af_o(fine_af_o), .fine_br_o(fine_br_o),
    .fine_bf_o(fine_bf_o), .phase_trig_o(phase_trig_o),
    .sample_trig_o(sample_trig_o), .blank_a_o(blank_a_o), .blank_b_o(blank_b_o));

  task automatic chk(input int got, input int exp, input string tag, input int v);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s at count %0d: got %0d expected %0d", tag, v, got, exp);
    end
  endtask

  function automatic int lvl(input int r, input int f, input int p, input int v);
    if (f > p) return 1;
    if (r >= f) return 0;
    if (v == 0) return 0;
    return (v > r && v <= f) ? 1 : 0;
  endfunction

  function automatic int blk(input int r, input int f, input int p, input int l, input int v);
    if (f > p || r >= f || v == 0) return 0;
    return ((v > r && v <= r + l) || (v > f && v <= f + l)) ? 1 : 0;
  endfunction

  function automatic int smp(input cfg_t c, input int v);
    int pos = (v == 0) ? c.p : v - 1;
    int gap = (c.p + 1) >> c.ovs;
    for (int k = 0; k < (1 << c.ovs); k++) begin
      int t = c.sm * 4 + k * gap;
      if (t <= c.p && t == pos) return 1;
    end
    return 0;
  endfunction

  task automatic check_cycle(input cfg_t c, input int v, input bit shd);
    int fa = (c.e2 + c.adj) >> 4;
    int fb = (c.e4 + c.adj) >> 4;
    int rb = c.e3 >> 4;
    string ta = shd ? "R8" : ((v == c.e1 || v == c.e1 + 1) ? "R2" : "R3");
    chk(int'(cnt_o), v, shd ? "R8" : "R1", v);
    chk(int'(pwm_a_o), lvl(c.e1, fa, c.p, v), ta, v);
    chk(int'(pwm_b_o), lvl(rb, fb, c.p, v), shd ? "R8" : "R4", v);
    chk(int'(phase_trig_o), ((v == 0) ? (c.ph == c.p) : (v - 1 == c.ph)) ? 1 : 0, shd ? "R8" : "R6", v);
    chk(int'(sample_trig_o), smp(c, v), shd ? "R8" : "R7", v);
    chk(int'(blank_a_o), blk(c.e1, fa, c.p, c.l, v), shd ? "R8" : "R9", v);
    chk(int'(blank_b_o), blk(rb, fb, c.p, c.l, v), shd ? "R8" : "R9", v);
    chk(int'(fine_af_o), (c.e2 + c.adj) & 15, shd ? "R8" : "R5", v);
    chk(int'(fine_br_o), c.e3 & 15, shd ? "R8" : "R5", v);
    chk(int'(fine_bf_o), (c.e4 + c.adj) & 15, shd ? "R8" : "R5", v);
  endtask

  task automatic apply(input cfg_t c);
    period_i = 14'(c.p); rise_a_i = 14'(c.e1); fall_a_i = 18'(c.e2);
    rise_b_i = 18'(c.e3); fall_b_i = 18'(c.e4); trim_i = 18'(c.adj);
    phase_i = 14'(c.ph); sample_i = 12'(c.sm); ovs_i = 2'(c.ovs);
    blank_len_i = 6'(c.l);
  endtask

  // Entry and exit: just after a falling edge with the counter at 0.
  task automatic run_period(input cfg_t c, input bit do_chk, input bit swap, input cfg_t nx);
    for (int v = 0; v <= c.p; v++) begin
      if (do_chk) check_cycle(c, v, 1'b0);
      else if (swap && v > c.p / 2) check_cycle(c, v, 1'b1);
      if (swap && v == c.p / 2) apply(nx);
      @(negedge clk);
    end
  endtask

  task automatic report;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  cfg_t cs [6];

  initial begin
    cs[0] = '{p:59, e1:5,  e2:323,  e3:480,  e4:727,  adj:0,   ph:10, sm:2, ovs:0, l:3};
    cs[1] = '{p:79, e1:10, e2:329,  e3:484,  e4:648,  adj:74,  ph:40, sm:3, ovs:1, l:3};
    cs[2] = '{p:99, e1:0,  e2:801,  e3:974,  e4:1442, adj:63,  ph:0,  sm:5, ovs:3, l:5};
    cs[3] = '{p:39, e1:5,  e2:800,  e3:160,  e4:160,  adj:0,   ph:39, sm:9, ovs:1, l:4};
    cs[4] = '{p:31, e1:3,  e2:511,  e3:133,  e4:321,  adj:0,   ph:15, sm:1, ovs:2, l:0};
    cs[5] = '{p:7,  e1:1,  e2:48,   e3:32,   e4:80,   adj:0,   ph:6,  sm:0, ovs:3, l:2};
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R10: all outputs low while reset is held
    chk(int'(cnt_o), 0, "R10", 0);
    chk(int'(pwm_a_o | pwm_b_o), 0, "R10", 0);
    chk(int'(phase_trig_o | sample_trig_o), 0, "R10", 0);
    chk(int'(blank_a_o | blank_b_o), 0, "R10", 0);
    apply(cs[0]);
    rst_n = 1'b1;
    @(negedge clk);
    chk(int'(cnt_o), 0, "R10", 0);
    chk(int'(pwm_a_o), 0, "R10", 0);
    run_period(cs[0], 1'b0, 1'b0, cs[0]);
    run_period(cs[0], 1'b1, 1'b0, cs[0]);
    for (int i = 1; i < 6; i++) begin
      run_period(cs[i-1], 1'b0, 1'b1, cs[i]);
      run_period(cs[i], 1'b0, 1'b0, cs[i]);
      run_period(cs[i], 1'b1, 1'b0, cs[i]);
    end
    report();
  end

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: got hung run expected completion");
    report();
  end
endmodule